// File: doc/BRIEF.md
# Message Object Request Arbiter

This block decides, for a bank of message objects, which object a CAN controller sends next and which object takes a frame that has just been received. Transmit selection is a fixed priority by object number. Among objects that are valid and have a transmit request pending, the lowest index wins. The result is available in the same cycle, together with a valid flag that is low when no object is eligible.

On receive, the protocol engine pulses a strobe together with the identifier and direction bit of the frame. The arbiter latches these values and, in the following cycle, chooses the storage object and updates that object's flags. Objects form FIFO groups. An object without its end-of-group flag chains into the next higher object, and the highest object always closes its group. A frame goes into the lowest matching object that holds no unread data. When every matching object of a group is full, the frame overwrites the last object of the group and that object's lost-message flag is set. The arbiter owns the per-object request, new-data, interrupt-pending and lost flags and presents them as vectors.

A small state machine orders the receive path. ST_IDLE waits for a strobe. ST_STORE performs the store for the latched frame. The transitions are IDLE_TO_STORE on a strobe, STORE_TO_STORE on a strobe that arrives while a store is in progress, and STORE_TO_IDLE otherwise.

Top module: `msgobj_arbiter`

## Requirements
- R1: When at least one object is valid with its request flag set, tx_sel_valid is high and tx_sel_idx is the lowest such index. With no eligible object, tx_sel_valid is low and tx_sel_idx is 0.
- R2: An object with obj_valid low takes part in neither transmit selection nor receive selection.
- R3: In the cycle after an rx_strobe, rx_store_valid goes high with rx_store_idx set to the lowest matching object whose new-data flag is clear. At the next edge, that object's new-data and interrupt-pending flags become 1.
- R4: An object matches when its direction bit equals rx_dir and its identifier equals rx_id. If its use-mask bit is set, only the bits set in its mask are compared. If the use-mask bit is clear, all bits are compared.
- R5: An object with obj_eob low chains into the next higher object. An object with obj_eob high, and the highest object in all cases, ends its group. A full object is skipped only when it is not the end of its group.
- R6: When the chosen object already holds unread data (the end of a full group), rx_overwrite is high during the store, and the object's lost flag is set at the edge.
- R7: A frame that matches no object is dropped. rx_store_valid stays low and no flag changes.
- R8: A tx_done pulse clears the request flag of object tx_done_idx. It sets that object's interrupt-pending flag only if obj_txie is set for that object.
- R9: sw_txrqst_set sets request flags. sw_newdat_clr clears new-data and lost flags. sw_intpnd_clr clears interrupt-pending flags. If a hardware set and a software clear hit the same flag in the same cycle, the set wins. A software request set wins over a tx_done clear.
- R10: In every flag vector, bit i belongs to object index i, so the first object is at bit 0.
- R11: After reset, all flag vectors are zero, all strobed outputs are low, and the FSM is in ST_IDLE.
- R12: Strobes in consecutive cycles are each stored, one store per cycle, in strobe order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_valid | input | N | Per-object valid flag |
| obj_dir | input | N | Per-object direction bit (1 = transmit) |
| obj_eob | input | N | Per-object end-of-group flag |
| obj_umask | input | N | Per-object use-mask flag |
| obj_txie | input | N | Per-object transmit interrupt enable |
| obj_id | input | N*ID_W | Identifiers, object i at bits [i*ID_W +: ID_W] |
| obj_mask | input | N*ID_W | Acceptance masks, same layout as obj_id |
| sw_txrqst_set | input | N | Set request flags |
| sw_newdat_clr | input | N | Clear new-data and lost flags |
| sw_intpnd_clr | input | N | Clear interrupt-pending flags |
| tx_done | input | 1 | Transmission of tx_done_idx finished |
| tx_done_idx | input | IDX_W | Object that finished transmitting |
| rx_strobe | input | 1 | Accepted frame available |
| rx_id | input | ID_W | Identifier of the received frame |
| rx_dir | input | 1 | Direction bit of the received frame |
| tx_sel_valid | output | 1 | An object is eligible to transmit |
| tx_sel_idx | output | IDX_W | Object selected to transmit |
| rx_store_valid | output | 1 | Store taking place this cycle |
| rx_store_idx | output | IDX_W | Object receiving the frame |
| rx_overwrite | output | 1 | Store overwrites unread data |
| txrqst_vec | output | N | Request flags |
| newdat_vec | output | N | New-data flags |
| intpnd_vec | output | N | Interrupt-pending flags |
| msglst_vec | output | N | Lost-message flags |

## Verification
The assertions assume that tx_done names an object whose request flag is set, and that rx_strobe is low during reset and in the first cycle after reset release. The stimulus keeps within these limits: it drives tx_done only for objects it has already requested, and it holds rx_strobe low across reset. The object configuration is held steady while a store is pending, so a receive decision always sees one consistent setup. The reference model recomputes the acceptance and group rules from the requirements on every cycle, with overlapping software clears placed on purpose in store cycles.

// File: rtl/msgobj_arb_pkg.sv
package msgobj_arb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_STORE = 1'b1
    } arb_state_t;
endpackage

// File: rtl/msgobj_prio_enc.sv
module msgobj_prio_enc #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Descending scan so the lowest requesting index is written last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/msgobj_accept.sv
module msgobj_accept #(
    parameter int N    = 32,
    parameter int ID_W = 29
) (
    input  logic [N-1:0]      obj_valid,
    input  logic [N-1:0]      obj_dir,
    input  logic [N-1:0]      obj_umask,
    input  logic [N*ID_W-1:0] obj_id,
    input  logic [N*ID_W-1:0] obj_mask,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_dir,
    output logic [N-1:0]      match
);
    for (genvar g = 0; g < N; g++) begin : g_obj
        logic [ID_W-1:0] care;
        assign care = obj_umask[g] ? obj_mask[g*ID_W +: ID_W] : {ID_W{1'b1}};
        assign match[g] = obj_valid[g] && (obj_dir[g] == frm_dir) &&
                          (((obj_id[g*ID_W +: ID_W] ^ frm_id) & care) == '0);
    end
endmodule

// File: rtl/msgobj_arbiter.sv
module msgobj_arbiter
    import msgobj_arb_pkg::*;
#(
    parameter int N    = 32,
    parameter int ID_W = 29,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      obj_valid,
    input  logic [N-1:0]      obj_dir,
    input  logic [N-1:0]      obj_eob,
    input  logic [N-1:0]      obj_umask,
    input  logic [N-1:0]      obj_txie,
    input  logic [N*ID_W-1:0] obj_id,
    input  logic [N*ID_W-1:0] obj_mask,
    input  logic [N-1:0]      sw_txrqst_set,
    input  logic [N-1:0]      sw_newdat_clr,
    input  logic [N-1:0]      sw_intpnd_clr,
    input  logic              tx_done,
    input  logic [IDX_W-1:0]  tx_done_idx,
    input  logic              rx_strobe,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_dir,
    output logic              tx_sel_valid,
    output logic [IDX_W-1:0]  tx_sel_idx,
    output logic              rx_store_valid,
    output logic [IDX_W-1:0]  rx_store_idx,
    output logic              rx_overwrite,
    output logic [N-1:0]      txrqst_vec,
    output logic [N-1:0]      newdat_vec,
    output logic [N-1:0]      intpnd_vec,
    output logic [N-1:0]      msglst_vec
);
    localparam logic [N-1:0] TOP_END = {1'b1, {(N-1){1'b0}}};

    arb_state_t      state, state_nx;
    logic [ID_W-1:0] lat_id;
    logic            lat_dir;

    logic [N-1:0] txrqst_q, newdat_q, intpnd_q, msglst_q;
    logic [N-1:0] txrqst_d, newdat_d, intpnd_d, msglst_d;

    logic [N-1:0]     match, rx_cand, group_end;
    logic             rx_found;
    logic [IDX_W-1:0] rx_idx;
    logic             done_ok;

    // Transmit: lowest valid object with a pending request.
    msgobj_prio_enc #(.N(N)) u_tx_enc (
        .req   (txrqst_q & obj_valid),
        .found (tx_sel_valid),
        .idx   (tx_sel_idx)
    );

    msgobj_accept #(.N(N), .ID_W(ID_W)) u_accept (
        .obj_valid (obj_valid),
        .obj_dir   (obj_dir),
        .obj_umask (obj_umask),
        .obj_id    (obj_id),
        .obj_mask  (obj_mask),
        .frm_id    (lat_id),
        .frm_dir   (lat_dir),
        .match     (match)
    );

    // A full object is only a candidate if it closes its group.
    assign group_end = obj_eob | TOP_END;
    assign rx_cand   = match & (~newdat_q | group_end);

    msgobj_prio_enc #(.N(N)) u_rx_enc (
        .req   (rx_cand),
        .found (rx_found),
        .idx   (rx_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lat_id  <= '0;
            lat_dir <= 1'b0;
        end else begin
            state <= state_nx;
            if (rx_strobe) begin
                lat_id  <= rx_id;
                lat_dir <= rx_dir;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx       = state;
        rx_store_valid = 1'b0;
        rx_store_idx   = '0;
        rx_overwrite   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rx_strobe) state_nx = ST_STORE;
            end
            ST_STORE: begin
                rx_store_valid = rx_found;
                rx_store_idx   = rx_found ? rx_idx : '0;
                rx_overwrite   = rx_found && newdat_q[rx_idx];
                state_nx       = rx_strobe ? ST_STORE : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign done_ok = tx_done && (int'(tx_done_idx) < N);

    // Flag updates: software clears first, then hardware sets override.
    always_comb begin
        txrqst_d = txrqst_q;
        if (done_ok) txrqst_d[tx_done_idx] = 1'b0;
        txrqst_d = txrqst_d | sw_txrqst_set;

        newdat_d = newdat_q & ~sw_newdat_clr;
        msglst_d = msglst_q & ~sw_newdat_clr;
        intpnd_d = intpnd_q & ~sw_intpnd_clr;

        if (done_ok && obj_txie[tx_done_idx]) intpnd_d[tx_done_idx] = 1'b1;
        if (rx_store_valid) begin
            newdat_d[rx_store_idx] = 1'b1;
            intpnd_d[rx_store_idx] = 1'b1;
            if (rx_overwrite) msglst_d[rx_store_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txrqst_q <= '0;
            newdat_q <= '0;
            intpnd_q <= '0;
            msglst_q <= '0;
        end else begin
            txrqst_q <= txrqst_d;
            newdat_q <= newdat_d;
            intpnd_q <= intpnd_d;
            msglst_q <= msglst_d;
        end
    end

    assign txrqst_vec = txrqst_q;
    assign newdat_vec = newdat_q;
    assign intpnd_vec = intpnd_q;
    assign msglst_vec = msglst_q;
endmodule

// File: rtl/msgobj_arbiter_chk.sv
module msgobj_arbiter_chk #(
    parameter int N    = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     obj_valid,
    input logic [N-1:0]     sw_txrqst_set,
    input logic             tx_done,
    input logic [IDX_W-1:0] tx_done_idx,
    input logic             rx_strobe,
    input logic             tx_sel_valid,
    input logic [IDX_W-1:0] tx_sel_idx,
    input logic             rx_store_valid,
    input logic [IDX_W-1:0] rx_store_idx,
    input logic             rx_overwrite,
    input logic [N-1:0]     txrqst_vec,
    input logic [N-1:0]     newdat_vec,
    input logic [N-1:0]     intpnd_vec,
    input logic [N-1:0]     msglst_vec
);
    logic [N-1:0] below_sel;
    assign below_sel = (N'(1) << tx_sel_idx) - N'(1);

    a_r1_sel_is_requested: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sel_valid |-> (txrqst_vec[tx_sel_idx] && obj_valid[tx_sel_idx]));

    a_r1_sel_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sel_valid |-> ((txrqst_vec & obj_valid & below_sel) == '0));

    a_r3_store_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store_valid |=> (newdat_vec[$past(rx_store_idx)] && intpnd_vec[$past(rx_store_idx)]));

    a_r6_overwrite_marks_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store_valid && rx_overwrite) |=> msglst_vec[$past(rx_store_idx)]);

    a_r12_store_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store_valid |-> $past(rx_strobe));

    a_r8_done_clears_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !sw_txrqst_set[tx_done_idx]) |=> !txrqst_vec[$past(tx_done_idx)]);
endmodule

bind msgobj_arbiter msgobj_arbiter_chk #(.N(N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .obj_valid      (obj_valid),
    .sw_txrqst_set  (sw_txrqst_set),
    .tx_done        (tx_done),
    .tx_done_idx    (tx_done_idx),
    .rx_strobe      (rx_strobe),
    .tx_sel_valid   (tx_sel_valid),
    .tx_sel_idx     (tx_sel_idx),
    .rx_store_valid (rx_store_valid),
    .rx_store_idx   (rx_store_idx),
    .rx_overwrite   (rx_overwrite),
    .txrqst_vec     (txrqst_vec),
    .newdat_vec     (newdat_vec),
    .intpnd_vec     (intpnd_vec),
    .msglst_vec     (msglst_vec)
);

// File: tb/msgobj_arbiter_test.sv
`timescale 1ns/1ps
module msgobj_arbiter_test;
    localparam int N = 8;
    localparam int ID_W = 11;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0] obj_valid = '0, obj_dir = '0, obj_eob = '0, obj_umask = '0, obj_txie = '0;
    logic [N*ID_W-1:0] obj_id = '0, obj_mask = '0;
    logic [N-1:0] sw_txrqst_set = '0, sw_newdat_clr = '0, sw_intpnd_clr = '0;
    logic tx_done = 1'b0;
    logic [IDX_W-1:0] tx_done_idx = '0;
    logic rx_strobe = 1'b0;
    logic [ID_W-1:0] rx_id = '0;
    logic rx_dir = 1'b0;

    logic tx_sel_valid, rx_store_valid, rx_overwrite;
    logic [IDX_W-1:0] tx_sel_idx, rx_store_idx;
    logic [N-1:0] txrqst_vec, newdat_vec, intpnd_vec, msglst_vec;

    msgobj_arbiter #(.N(N), .ID_W(ID_W)) uut (.*);

    int checks = 0;
    int fails = 0;

    // Reference model state
    logic [N-1:0] m_tx = '0, m_nd = '0, m_ip = '0, m_ml = '0;
    bit m_busy = 0;
    logic [ID_W-1:0] m_id = '0;
    logic m_dir = 1'b0;

    function automatic bit m_match(int i);
        logic [ID_W-1:0] care;
        care = obj_umask[i] ? obj_mask[i*ID_W +: ID_W] : {ID_W{1'b1}};
        return obj_valid[i] && (obj_dir[i] == m_dir) &&
               (((obj_id[i*ID_W +: ID_W] ^ m_id) & care) == '0);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_obj(int i, bit v, bit d, bit e, bit um, bit ie, int id, int mk);
        obj_valid[i] = v; obj_dir[i] = d; obj_eob[i] = e; obj_umask[i] = um; obj_txie[i] = ie;
        obj_id[i*ID_W +: ID_W] = ID_W'(id);
        obj_mask[i*ID_W +: ID_W] = ID_W'(mk);
    endtask

    // One clock: compare at negedge, advance model, clear pulses after the edge.
    task automatic step(string tag);
        bit etv, erv, eow;
        int eti, eri;
        logic [N-1:0] nt, nd, ip, ml;
        @(negedge clk);
        etv = 0; eti = 0;
        for (int i = N - 1; i >= 0; i--) if (m_tx[i] && obj_valid[i]) begin etv = 1; eti = i; end
        erv = 0; eri = 0; eow = 0;
        if (m_busy) begin
            for (int i = N - 1; i >= 0; i--)
                if (m_match(i) && (!m_nd[i] || obj_eob[i] || i == N - 1)) begin erv = 1; eri = i; end
            eow = erv && m_nd[eri];
        end
        check("R1", "tx_sel_valid", int'(tx_sel_valid), int'(etv));
        check("R1", "tx_sel_idx", int'(tx_sel_idx), eti);
        check(tag, "rx_store_valid", int'(rx_store_valid), int'(erv));
        check(tag, "rx_store_idx", int'(rx_store_idx), eri);
        check(tag, "rx_overwrite", int'(rx_overwrite), int'(eow));
        check(tag, "txrqst_vec", int'(txrqst_vec), int'(m_tx));
        check(tag, "newdat_vec", int'(newdat_vec), int'(m_nd));
        check(tag, "intpnd_vec", int'(intpnd_vec), int'(m_ip));
        check(tag, "msglst_vec", int'(msglst_vec), int'(m_ml));
        nt = m_tx;
        if (tx_done) nt[tx_done_idx] = 1'b0;
        nt = nt | sw_txrqst_set;
        nd = m_nd & ~sw_newdat_clr;
        ml = m_ml & ~sw_newdat_clr;
        ip = m_ip & ~sw_intpnd_clr;
        if (tx_done && obj_txie[tx_done_idx]) ip[tx_done_idx] = 1'b1;
        if (erv) begin nd[eri] = 1'b1; ip[eri] = 1'b1; if (eow) ml[eri] = 1'b1; end
        @(posedge clk);
        m_tx = nt; m_nd = nd; m_ip = ip; m_ml = ml;
        m_busy = rx_strobe;
        if (rx_strobe) begin m_id = rx_id; m_dir = rx_dir; end
        #0.5;
        rx_strobe = 1'b0; tx_done = 1'b0;
        sw_txrqst_set = '0; sw_newdat_clr = '0; sw_intpnd_clr = '0;
    endtask

    task automatic rx(int id, bit d);
        rx_id = ID_W'(id); rx_dir = d; rx_strobe = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Receive FIFO 0..2 (masked, ends at 2), single exact object 3,
        // transmit objects 4..7 (6 invalid), object 5 also answers dir=1 id 0x105.
        set_obj(0, 1, 0, 0, 1, 0, 'h100, 'h7F0);
        set_obj(1, 1, 0, 0, 1, 0, 'h100, 'h7F0);
        set_obj(2, 1, 0, 1, 1, 0, 'h100, 'h7F0);
        set_obj(3, 1, 0, 1, 0, 0, 'h200, 'h000);
        set_obj(4, 1, 1, 0, 0, 1, 'h300, 'h000);
        set_obj(5, 1, 1, 0, 0, 1, 'h105, 'h000);
        set_obj(6, 0, 1, 0, 0, 1, 'h306, 'h000);
        set_obj(7, 1, 1, 0, 0, 0, 'h307, 'h000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "tx_sel_valid", int'(tx_sel_valid), 0);
        check("R11", "rx_store_valid", int'(rx_store_valid), 0);
        check("R11", "flags", int'(txrqst_vec | newdat_vec | intpnd_vec | msglst_vec), 0);
        rst_n = 1'b1;
        @(posedge clk); #0.5;
        step("R11");

        // R1 / R2 / R10: fixed priority among valid requests
        sw_txrqst_set = 8'b1111_0000; step("R1");
        step("R10");
        tx_done = 1'b1; tx_done_idx = 3'd4; step("R8");
        step("R1");
        tx_done = 1'b1; tx_done_idx = 3'd5; step("R8");
        tx_done = 1'b1; tx_done_idx = 3'd7; step("R8");
        step("R2");
        // R9: request set wins over done clear
        sw_txrqst_set = 8'b1000_0000; step("R9");
        tx_done = 1'b1; tx_done_idx = 3'd7; sw_txrqst_set = 8'b1000_0000; step("R9");
        step("R9");
        sw_intpnd_clr = 8'b0011_0000; step("R9");

        // R3 / R4 / R5 / R6: FIFO fill and overwrite
        rx('h105, 0); step("R3");
        step("R3");
        rx('h10A, 0); step("R4");
        step("R5");
        rx('h10F, 0); step("R5");
        step("R5");
        rx('h101, 0); step("R6");
        step("R6");
        rx('h200, 0); step("R4");
        step("R4");
        rx('h201, 0); step("R7");
        step("R7");
        rx('h200, 0); step("R6");
        step("R6");
        rx('h105, 1); step("R4");
        step("R4");

        // R9: software clear collides with hardware set on object 0
        sw_newdat_clr = 8'b0000_0111; sw_intpnd_clr = 8'b0000_1111; step("R9");
        rx('h10C, 0); step("R9");
        sw_newdat_clr = 8'b0000_0001; sw_intpnd_clr = 8'b0000_0001; step("R9");
        step("R9");

        // R12: back-to-back strobes
        sw_newdat_clr = 8'b0000_1111; step("R12");
        rx('h111, 0); step("R12");
        rx('h112, 0); step("R12");
        rx('h200, 0); step("R12");
        step("R12");
        step("R12");

        // R2: invalid receive object is skipped
        obj_valid[0] = 1'b0;
        sw_newdat_clr = 8'b1111_1111; step("R2");
        rx('h105, 0); step("R2");
        step("R2");
        step("R2");

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule